// File: doc/BRIEF.md
# Converter Wake-Up and Word Cadence Sequencer

This block decides when a delta-sigma converter may hand out its first fully settled conversion word, and from then on it paces those words at a fixed spacing. There are three ways to wake the converter, and each has its own settle length. The first is the release of the active-low reset, which includes a self-calibration. The second is a rising edge on the synchronisation input, which restarts the filter but does not calibrate. The third is leaving power-down, which also restarts without calibration and waits slightly longer than a sync. Every word strobe that follows the first one lies a whole number of word periods after the edge at which the wake event was recognised. Several converters that see the same sync edge therefore emit their words in lock-step.

The outputs drive the rest of the converter. A calibration-busy level tells the calibration engine to run. A one-cycle filter-restart pulse clears the decimator. An output-enable level gates the serial transmitter. A one-cycle word strobe tells the transmitter to start a frame. In modulator-only operation (mode input low), calibration and the filter restart are skipped, and the cadence starts one word period after the event. All settle lengths are parameters. Their defaults are the full-size counts, and a bench can shrink them.

Top module: `wake_sequencer`

## Requirements
- R1: While rst_n is low, all four outputs are low. They stay low until the reset release is recognised and the matching settle interval has run.
- R2: Let R be the first rising clock edge with rst_n high. Edge R+2 is the recognition edge E. With mode_i high at E, cal_busy_o is high from the cycle after E until the first strobe. The first word_stb_o pulse is seen in the cycle after edge E+RST_SETTLE (default 988205).
- R3: A sync is recognised at the first edge that samples sync_i high after it was sampled low. With mode_i high, this edge E gives a one-cycle filt_restart_o pulse in the cycle after E. The first strobe comes in the cycle after edge E+SYNC_SETTLE (default 5161). cal_busy_o stays low.
- R4: At every edge that samples pwdn_n_i low, out_en_o, word_stb_o and cal_busy_o go low, and all settle and cadence timing is abandoned.
- R5: The first edge that samples pwdn_n_i high after it was low is a power-up event E. It restarts the filter as R3 does, without calibration. The first strobe comes in the cycle after edge E+PWR_SETTLE (default 5168).
- R6: After the first strobe, word_stb_o is a one-cycle pulse every WORD_PERIOD (default 64) cycles. The pulses fall in the cycles after edges E+S+n*WORD_PERIOD, where S is the settle length of the last event.
- R7: out_en_o rises in the same cycle as the first strobe. It stays high until the next accepted wake event, power-down or reset.
- R8: With mode_i low at the event edge, no calibration and no filter-restart pulse occur. The settle length is WORD_PERIOD for all three causes.
- R9: A sync edge is ignored in three cases: while cal_busy_o is high, while pwdn_n_i is low, and before the reset release has been recognised. The strobe timing already in force is kept.
- R10: If one edge holds several events, power-up wins over sync. A sync that lands on the edge where a strobe is due suppresses that strobe and restarts the settle interval.
- R11: Holding sync_i high for many cycles causes only one restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Active-low reset; its release starts the calibrated wake-up |
| sync_i | input | 1 | Synchronisation request, acted on at its rising edge |
| pwdn_n_i | input | 1 | Active-low power-down |
| mode_i | input | 1 | 1 = filtered word mode, 0 = modulator-only mode |
| cal_busy_o | output | 1 | Self-calibration in progress |
| filt_restart_o | output | 1 | One-cycle pulse that clears the decimation filter |
| out_en_o | output | 1 | Settled words may be transmitted |
| word_stb_o | output | 1 | One-cycle strobe that starts each output word |

## Verification
Two of this block's functions can fall on the same edge. The first case is a sync recognition on the very edge where a word strobe is due. The bench watches the expected strobe times, which it computes itself, and raises sync_i just before one of those edges. It then checks that the strobe is missing, that out_en_o drops, and that the next strobe comes one sync settle interval later. The second case is a power-up and a sync edge on the same edge. The bench releases power-down and raises sync in the same half cycle, and judges by whether the first strobe follows the power-up settle length rather than the sync one. Every cycle, all four outputs are compared with values that the bench computes from event edges, settle lengths and modular arithmetic on the word period.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DOWN   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_RESET = 2'd0,
    CAUSE_SYNC  = 2'd1,
    CAUSE_PWRUP = 2'd2
  } wake_cause_e;

  // Settle length between the recognition edge and the first word strobe.
  function automatic int unsigned settle_cycles(
    input wake_cause_e cause,
    input logic        filt_on,
    input int unsigned rst_len,
    input int unsigned sync_len,
    input int unsigned pwr_len,
    input int unsigned period
  );
    if (!filt_on) return period;
    case (cause)
      CAUSE_RESET: return rst_len;
      CAUSE_PWRUP: return pwr_len;
      default:     return sync_len;
    endcase
  endfunction

  function automatic int unsigned max_of4(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c,
    input int unsigned d
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wake_event_detect.sv
module wake_event_detect #(
  parameter int unsigned REL_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pwdn_n_i,
  output logic start_evt,
  output logic sync_evt,
  output logic pwrup_evt
);

  logic [REL_DELAY:0] rel_q;
  logic               sync_q;
  logic               pwdn_q;

  // Release pipeline: fills with ones once reset is gone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= {rel_q[REL_DELAY-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      pwdn_q <= 1'b1;
    end else begin
      sync_q <= sync_i;
      pwdn_q <= pwdn_n_i;
    end
  end

  assign start_evt = rel_q[REL_DELAY-1] & ~rel_q[REL_DELAY];
  assign sync_evt  = sync_i & ~sync_q;
  assign pwrup_evt = pwdn_n_i & ~pwdn_q;

  a_r2_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !start_evt);

  a_r11_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_evt);

endmodule

// File: rtl/seq_down_timer.sv
module seq_down_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (run_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);

  a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !load_i) |=> !expired_o);

endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
  import wake_seq_pkg::*;
#(
  parameter int unsigned RST_SETTLE  = 988205,
  parameter int unsigned SYNC_SETTLE = 5161,
  parameter int unsigned PWR_SETTLE  = 5168,
  parameter int unsigned WORD_PERIOD = 64,
  parameter int unsigned REL_DELAY   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pwdn_n_i,
  input  logic mode_i,
  output logic cal_busy_o,
  output logic filt_restart_o,
  output logic out_en_o,
  output logic word_stb_o
);

  localparam int unsigned MAX_SETTLE =
    max_of4(RST_SETTLE, SYNC_SETTLE, PWR_SETTLE, WORD_PERIOD);
  localparam int unsigned SW = $clog2(MAX_SETTLE + 1);
  localparam int unsigned PW = $clog2(WORD_PERIOD + 1);

  // Named internal events, used by the assertions below.
  logic start_evt, sync_evt, pwrup_evt;
  logic settle_exp, cad_exp;

  seq_state_e  state_q, state_d;
  logic        stb_q, stb_d;
  logic        restart_q, restart_d;
  logic        cal_q, cal_d;
  logic        wake_go;
  wake_cause_e wake_cause;

  logic          st_load, st_clr, cad_load, cad_clr;
  logic [SW-1:0] st_val;

  wake_event_detect #(.REL_DELAY(REL_DELAY)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .pwdn_n_i  (pwdn_n_i),
    .start_evt (start_evt),
    .sync_evt  (sync_evt),
    .pwrup_evt (pwrup_evt)
  );

  seq_down_timer #(.W(SW)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (st_clr),
    .load_i     (st_load),
    .load_val_i (st_val),
    .expired_o  (settle_exp)
  );

  seq_down_timer #(.W(PW)) u_cadence (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cad_clr),
    .load_i     (cad_load),
    .load_val_i (PW'(WORD_PERIOD - 1)),
    .expired_o  (cad_exp)
  );

  // Event arbitration: reset start, then power-up, then sync.
  always_comb begin
    wake_go    = 1'b0;
    wake_cause = CAUSE_SYNC;
    if (start_evt) begin
      wake_go    = 1'b1;
      wake_cause = CAUSE_RESET;
    end else if (pwrup_evt && (state_q != ST_IDLE)) begin
      wake_go    = 1'b1;
      wake_cause = CAUSE_PWRUP;
    end else if (sync_evt && !cal_q &&
                 ((state_q == ST_SETTLE) || (state_q == ST_RUN))) begin
      wake_go    = 1'b1;
      wake_cause = CAUSE_SYNC;
    end
  end

  always_comb begin
    state_d   = state_q;
    stb_d     = 1'b0;
    restart_d = 1'b0;
    cal_d     = cal_q;
    st_load   = 1'b0;
    st_clr    = 1'b0;
    st_val    = '0;
    cad_load  = 1'b0;
    cad_clr   = 1'b0;
    if (!pwdn_n_i) begin
      state_d = ST_DOWN;
      cal_d   = 1'b0;
      st_clr  = 1'b1;
      cad_clr = 1'b1;
    end else if (wake_go) begin
      state_d   = ST_SETTLE;
      st_load   = 1'b1;
      st_val    = SW'(settle_cycles(wake_cause, mode_i, RST_SETTLE,
                                    SYNC_SETTLE, PWR_SETTLE, WORD_PERIOD) - 1);
      cad_clr   = 1'b1;
      restart_d = mode_i;
      cal_d     = mode_i && (wake_cause == CAUSE_RESET);
    end else if ((state_q == ST_SETTLE) && settle_exp) begin
      state_d  = ST_RUN;
      stb_d    = 1'b1;
      st_clr   = 1'b1;
      cad_load = 1'b1;
      cal_d    = 1'b0;
    end else if ((state_q == ST_RUN) && cad_exp) begin
      stb_d    = 1'b1;
      cad_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stb_q     <= 1'b0;
      restart_q <= 1'b0;
      cal_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      stb_q     <= stb_d;
      restart_q <= restart_d;
      cal_q     <= cal_d;
    end
  end

  assign cal_busy_o     = cal_q;
  assign filt_restart_o = restart_q;
  assign out_en_o       = (state_q == ST_RUN);
  assign word_stb_o     = stb_q;

  a_r6_strobe_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |=> !word_stb_o);

  a_r7_strobe_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> out_en_o);

  a_r7_enable_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> word_stb_o);

  a_r2_cal_not_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_o |-> !out_en_o);

  a_r3_restart_not_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    filt_restart_o |-> !out_en_o);

  a_r4_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwdn_n_i |=> (!out_en_o && !word_stb_o && !cal_busy_o));

  a_r9_cal_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy_o && pwdn_n_i) |=> (cal_busy_o || word_stb_o));

endmodule

// File: tb/test_wake_sequencer.sv
module test_wake_sequencer;

  localparam int RS = 300;
  localparam int SS = 70;
  localparam int PS = 77;
  localparam int P  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sync_i = 1'b0;
  logic pwdn_n = 1'b1;
  logic mode = 1'b1;
  logic cal_busy, filt_restart, out_en, word_stb;

  wake_sequencer #(
    .RST_SETTLE(RS), .SYNC_SETTLE(SS), .PWR_SETTLE(PS), .WORD_PERIOD(P), .REL_DELAY(2)
  ) i_wake_sequencer (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .pwdn_n_i(pwdn_n), .mode_i(mode),
    .cal_busy_o(cal_busy), .filt_restart_o(filt_restart),
    .out_en_o(out_en), .word_stb_o(word_stb)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Bench model of the last accepted wake event.
  bit sess = 1'b0, down = 1'b0, cal_s = 1'b0, mode_s = 1'b0;
  int e0 = 0, slen = 1;

  function automatic bit e_en(int k);
    return sess && (k >= e0 + slen);
  endfunction
  function automatic bit e_stb(int k);
    return e_en(k) && (((k - e0 - slen) % P) == 0);
  endfunction
  function automatic bit e_cal(int k);
    return sess && cal_s && (k >= e0) && (k < e0 + slen);
  endfunction
  function automatic bit e_rst(int k);
    return sess && mode_s && (k == e0);
  endfunction

  task automatic chk(string sig, string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s [%s] cycle %0d: got %b expected %b", req, sig, tag, cyc, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("word_stb", "R6", word_stb, e_stb(cyc));
      chk("out_en", "R7", out_en, e_en(cyc));
      chk("cal_busy", "R2", cal_busy, e_cal(cyc));
      chk("filt_restart", "R3", filt_restart, e_rst(cyc));
    end
  end

  task automatic run_to(int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic do_reset(int low_cycles, logic m);
    @(negedge clk);
    rst_n = 1'b0;
    sess = 1'b0;
    down = 1'b0;
    repeat (low_cycles) @(negedge clk);
    mode = m;
    rst_n = 1'b1;
    sess = 1'b1;
    e0 = cyc + 3;
    mode_s = m;
    cal_s = m;
    slen = m ? RS : P;
  endtask

  task automatic accept_sync();
    if (sess && !down && (cyc + 1 > e0) && !e_cal(cyc)) begin
      e0 = cyc + 1;
      slen = mode ? SS : P;
      cal_s = 1'b0;
      mode_s = mode;
    end
  endtask

  task automatic sync_pulse(int hold);
    @(negedge clk);
    sync_i = 1'b1;
    accept_sync();
    repeat (hold) @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic sync_on_strobe();
    @(negedge clk);
    while (!e_stb(cyc + 1)) @(negedge clk);
    sync_i = 1'b1;
    accept_sync();
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic power_down(int n);
    @(negedge clk);
    pwdn_n = 1'b0;
    sess = 1'b0;
    down = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(bit with_sync);
    @(negedge clk);
    pwdn_n = 1'b1;
    if (with_sync) sync_i = 1'b1;
    sess = 1'b1;
    down = 1'b0;
    e0 = cyc + 1;
    slen = mode ? PS : P;
    cal_s = 1'b0;
    mode_s = mode;
    if (with_sync) begin
      @(negedge clk);
      sync_i = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got hung expected finish");
      finish_run();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    // R1: reset held, then calibrated start (R2)
    tag = "R1";
    do_reset(4, 1'b1);
    tag = "R2";
    run_to(e0 + 40);
    // R9: sync during calibration is ignored
    tag = "R9";
    sync_pulse(3);
    tag = "R2 R6 R7";
    run_to(e0 + slen + 5 * P);
    // R3 and R11: sync held high restarts once
    tag = "R3 R11";
    sync_pulse(15);
    run_to(e0 + slen + 3 * P);
    // R10: sync on a due strobe edge
    tag = "R10";
    sync_on_strobe();
    run_to(e0 + slen + 3 * P);
    // R4: power-down, with a sync while down (R9)
    tag = "R4";
    power_down(12);
    tag = "R9";
    sync_pulse(2);
    repeat (5) @(negedge clk);
    // R5: power-up behaves like a sync with its own length
    tag = "R5";
    power_up(1'b0);
    run_to(e0 + slen + 3 * P);
    // R10: power-up and sync on the same edge
    tag = "R10";
    power_down(6);
    power_up(1'b1);
    run_to(e0 + slen + 3 * P);
    // R8: modulator-only mode for sync, reset and power-up
    tag = "R8";
    @(negedge clk);
    mode = 1'b0;
    sync_pulse(2);
    run_to(e0 + slen + 3 * P);
    do_reset(2, 1'b0);
    run_to(e0 + slen + 3 * P);
    power_down(4);
    power_up(1'b0);
    run_to(e0 + slen + 2 * P);
    // R1: reset in the middle of running, calibrated start again
    tag = "R1";
    do_reset(3, 1'b1);
    tag = "R2";
    run_to(e0 + slen + 2 * P);
    finish_run();
  end

endmodule